// File: doc/BRIEF.md
# Per-Cell Clocked Register Macrocell Array

This block is the output stage of an asynchronous-style programmable logic array. It holds ten identical cells. Each cell takes four sum terms, plus terms of its own for its clock, clear, set and drive enable, from an AND plane that sits outside the block. The four sum terms are ORed together. A per-cell polarity bit then decides the level that an active sum presents to the storage flop. Every cell captures on the rising edge of its own clock term, so the array can run up to ten unrelated clock domains.

Clear, set and a global preload act on the flops asynchronously. None of them passes through the polarity bit. A per-cell bypass bit routes the polarity-adjusted sum straight to the output in place of the flop. Each cell has a value output and a drive-enable output. The drive enable is true only when the cell's own enable term and the shared enable input are both high. A feedback output returns each cell's state to the AND plane. In registered mode that state is the flop. In bypass mode it is the output value.

Top module: `mcell_array`

## Requirements
- R1: While a cell's clear term is high, its flop holds 0, whatever its polarity bit and sum terms are, and rising edges on its clock term are ignored.
- R2: While a cell's set term is high and its clear term is low, its flop holds 1, whatever its polarity bit is.
- R3: When clear and set are high together, the flop holds 0.
- R4: On a rising edge of a cell's clock term, the flop takes the value D. D equals the polarity bit (0 or 1) when any of the four sum terms is high, and the inverse of the polarity bit when all four are low.
- R5: A clock edge on one cell changes no other cell's flop.
- R6: A rising edge on the preload input loads preload data bit i into flop i of every cell whose clear and set terms are low. Clear and set take priority over preload, and the loaded value holds after preload falls.
- R7: The polarity bit affects only data captured by a clock edge. Clear, set and preload results are the same for either polarity value.
- R8: With the bypass bit set to 1, the cell's value output follows D at once, with no clock edge, and the feedback output equals the value output.
- R9: With the bypass bit set to 0, the value output and the feedback output both equal the flop, and changes on the sum terms between clock edges leave them unchanged.
- R10: The drive-enable output of a cell is 1 exactly when that cell's enable term and the shared enable input are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sum_terms_i | input | NCELL*NTERM | Sum terms, cell c occupies bits [c*NTERM +: NTERM] |
| cell_clk_i | input | NCELL | Per-cell clock term, rising edge captures |
| cell_clr_i | input | NCELL | Per-cell asynchronous clear term, active high |
| cell_set_i | input | NCELL | Per-cell asynchronous set term, active high |
| cell_oe_i | input | NCELL | Per-cell drive-enable term |
| pol_cfg_i | input | NCELL | Per-cell polarity bit |
| byp_cfg_i | input | NCELL | Per-cell bypass bit, 1 selects the combinational path |
| share_oe_i | input | 1 | Shared drive enable for all cells, active high |
| preload_i | input | 1 | Preload strobe, rising edge loads all flops |
| preload_val_i | input | NCELL | Value loaded by the preload strobe |
| dout_o | output | NCELL | Cell output value |
| drive_o | output | NCELL | Cell output drive enable |
| fb_o | output | NCELL | Feedback to the AND plane |

## Verification
The checker samples every cell on its own clock edge. At each edge it confirms that clear leaves the flop at 0 even when set is also high, and that set alone leaves it at 1. It also confirms that a registered cell presents its flop on both value and feedback, that a bypassed cell feeds back its output value, and that drive enable never rises without the shared enable and the cell's term. The bench scenarios are what show the captured value following the polarity rule. They also show bypass responding with no clock, clock edges staying confined to one cell, and preload landing only on cells that are not cleared or set. These are also the only place the ignored clock under clear and the polarity-independence of clear, set and preload are checked.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int unsigned MC_CELLS = 10;
    localparam int unsigned MC_TERMS = 4;

    // static configuration of one cell
    typedef struct packed {
        logic pol;
        logic bypass;
    } mc_cfg_t;

    // asynchronous controls of one cell, in priority order
    typedef struct packed {
        logic clr;
        logic set;
        logic load;
    } mc_async_t;

    typedef enum logic {
        SRC_REG  = 1'b0,
        SRC_COMB = 1'b1
    } mc_src_e;

    // an active sum yields the polarity level, an idle sum its inverse
    function automatic logic mc_data(input logic any_term, input logic pol);
        return any_term ? pol : ~pol;
    endfunction

endpackage

// File: rtl/mc_sum_pol.sv
module mc_sum_pol
    import mc_pkg::*;
#(
    parameter int unsigned NTERM = MC_TERMS
) (
    input  logic [NTERM-1:0] terms_i,
    input  mc_cfg_t          cfg_i,
    output logic             d_o
);
    logic any_w;

    always_comb begin
        any_w = |terms_i;
        d_o   = mc_data(any_w, cfg_i.pol);
    end
endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic      cap_clk_i,
    input  mc_async_t ctl_i,
    input  logic      load_val_i,
    input  logic      d_i,
    output logic      q_o
);
    logic clr_w;
    logic set_w;
    logic load_w;

    assign clr_w  = ctl_i.clr;
    assign set_w  = ctl_i.set;
    assign load_w = ctl_i.load;

    always_ff @(posedge cap_clk_i or posedge clr_w or posedge set_w or posedge load_w) begin
        if (clr_w) begin
            q_o <= 1'b0;
        end else if (set_w) begin
            q_o <= 1'b1;
        end else if (load_w) begin
            q_o <= load_val_i;
        end else begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/mc_drive.sv
module mc_drive
    import mc_pkg::*;
(
    input  mc_cfg_t cfg_i,
    input  logic    d_i,
    input  logic    q_i,
    input  logic    oe_term_i,
    input  logic    share_oe_i,
    output logic    val_o,
    output logic    drv_o,
    output logic    fb_o
);
    mc_src_e src_w;

    always_comb begin
        src_w = cfg_i.bypass ? SRC_COMB : SRC_REG;
        unique case (src_w)
            SRC_COMB: val_o = d_i;
            default:  val_o = q_i;
        endcase
        // bypass returns the pin value, registered mode returns the flop
        fb_o  = (src_w == SRC_COMB) ? val_o : q_i;
        drv_o = oe_term_i & share_oe_i;
    end
endmodule

// File: rtl/mcell_array.sv
module mcell_array
    import mc_pkg::*;
#(
    parameter int unsigned NCELL = MC_CELLS,
    parameter int unsigned NTERM = MC_TERMS
) (
    input  logic [NCELL*NTERM-1:0] sum_terms_i,
    input  logic [NCELL-1:0]       cell_clk_i,
    input  logic [NCELL-1:0]       cell_clr_i,
    input  logic [NCELL-1:0]       cell_set_i,
    input  logic [NCELL-1:0]       cell_oe_i,
    input  logic [NCELL-1:0]       pol_cfg_i,
    input  logic [NCELL-1:0]       byp_cfg_i,
    input  logic                   share_oe_i,
    input  logic                   preload_i,
    input  logic [NCELL-1:0]       preload_val_i,
    output logic [NCELL-1:0]       dout_o,
    output logic [NCELL-1:0]       drive_o,
    output logic [NCELL-1:0]       fb_o
);
    localparam int unsigned TERM_BITS = NCELL * NTERM;

    logic [NCELL-1:0] d_w;
    logic [NCELL-1:0] q_w;

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        mc_cfg_t   cfg_w;
        mc_async_t ctl_w;

        assign cfg_w.pol    = pol_cfg_i[c];
        assign cfg_w.bypass = byp_cfg_i[c];
        assign ctl_w.clr    = cell_clr_i[c];
        assign ctl_w.set    = cell_set_i[c];
        assign ctl_w.load   = preload_i;

        mc_sum_pol #(.NTERM(NTERM)) u_sum (
            .terms_i (sum_terms_i[(c*NTERM) % TERM_BITS +: NTERM]),
            .cfg_i   (cfg_w),
            .d_o     (d_w[c])
        );

        mc_store u_store (
            .cap_clk_i  (cell_clk_i[c]),
            .ctl_i      (ctl_w),
            .load_val_i (preload_val_i[c]),
            .d_i        (d_w[c]),
            .q_o        (q_w[c])
        );

        mc_drive u_drive (
            .cfg_i      (cfg_w),
            .d_i        (d_w[c]),
            .q_i        (q_w[c]),
            .oe_term_i  (cell_oe_i[c]),
            .share_oe_i (share_oe_i),
            .val_o      (dout_o[c]),
            .drv_o      (drive_o[c]),
            .fb_o       (fb_o[c])
        );
    end
endmodule

// File: rtl/mcell_array_chk.sv
module mcell_array_chk #(
    parameter int unsigned NCELL = 10
) (
    input logic [NCELL-1:0] cell_clk_i,
    input logic [NCELL-1:0] cell_clr_i,
    input logic [NCELL-1:0] cell_set_i,
    input logic [NCELL-1:0] cell_oe_i,
    input logic [NCELL-1:0] byp_cfg_i,
    input logic             share_oe_i,
    input logic [NCELL-1:0] dout_o,
    input logic [NCELL-1:0] drive_o,
    input logic [NCELL-1:0] fb_o,
    input logic [NCELL-1:0] q_w
);
    for (genvar g = 0; g < NCELL; g++) begin : g_chk
        // R1: clear keeps the flop low at every edge of its own clock
        a_r1_clear_holds_low: assert property (@(posedge cell_clk_i[g])
            cell_clr_i[g] |-> !q_w[g]);

        // R3: clear dominates set
        a_r3_clear_beats_set: assert property (@(posedge cell_clk_i[g])
            (cell_clr_i[g] && cell_set_i[g]) |-> !q_w[g]);

        // R2: set alone keeps the flop high
        a_r2_set_holds_high: assert property (@(posedge cell_clk_i[g])
            disable iff (cell_clr_i[g]) cell_set_i[g] |-> q_w[g]);

        // R9: registered cell shows its flop on value and feedback
        a_r9_reg_path: assert property (@(posedge cell_clk_i[g])
            disable iff (cell_clr_i[g])
            !byp_cfg_i[g] |-> (dout_o[g] == q_w[g] && fb_o[g] == q_w[g]));

        // R8: bypassed cell feeds back its output value
        a_r8_comb_feedback: assert property (@(posedge cell_clk_i[g])
            disable iff (cell_clr_i[g])
            byp_cfg_i[g] |-> (fb_o[g] == dout_o[g]));

        // R10: no drive without the shared enable and the cell term
        a_r10_drive_gate: assert property (@(posedge cell_clk_i[g])
            disable iff (cell_clr_i[g])
            drive_o[g] |-> (share_oe_i && cell_oe_i[g]));
    end
endmodule

bind mcell_array mcell_array_chk #(.NCELL(NCELL)) u_chk (
    .cell_clk_i (cell_clk_i),
    .cell_clr_i (cell_clr_i),
    .cell_set_i (cell_set_i),
    .cell_oe_i  (cell_oe_i),
    .byp_cfg_i  (byp_cfg_i),
    .share_oe_i (share_oe_i),
    .dout_o     (dout_o),
    .drive_o    (drive_o),
    .fb_o       (fb_o),
    .q_w        (q_w)
);

// File: tb/sim_mcell_array.sv
module sim_mcell_array;
    localparam int NC = 10;
    localparam int NT = 4;
    localparam int NV = 8;

    // {pol, bypass, sum terms[3:0], expected output}
    localparam logic [6:0] VEC [NV] = '{
        7'b1_0_0001_1,
        7'b1_0_0000_0,
        7'b0_0_1000_0,
        7'b0_0_0000_1,
        7'b1_1_0100_1,
        7'b0_1_0110_0,
        7'b0_1_0000_1,
        7'b1_0_1111_1
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [NC*NT-1:0] lt;
    logic [NC-1:0] ck, ar, ap, oet, pol, byp, pld;
    logic oep, ple;
    logic [NC-1:0] dout, den, fb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    mcell_array u0 (
        .sum_terms_i   (lt),
        .cell_clk_i    (ck),
        .cell_clr_i    (ar),
        .cell_set_i    (ap),
        .cell_oe_i     (oet),
        .pol_cfg_i     (pol),
        .byp_cfg_i     (byp),
        .share_oe_i    (oep),
        .preload_i     (ple),
        .preload_val_i (pld),
        .dout_o        (dout),
        .drive_o       (den),
        .fb_o          (fb)
    );

    task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        ck[k] = 1'b1;
        @(negedge clk);
        ck[k] = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] exp;
        lt = '0; ck = '0; ar = '1; ap = '0; oet = '0;
        pol = '0; byp = '0; pld = '0; oep = 1'b0; ple = 1'b0;
        step();
        step();
        chk("R1 reset state fb", fb, '0);

        // table walk: one cell per vector, all others held cleared then idle
        for (int i = 0; i < NV; i++) begin
            step();
            ar = '1; ap = '0; pol = '0; byp = '0; lt = '0;
            step();
            ar = '0;
            pol[i] = VEC[i][6];
            byp[i] = VEC[i][5];
            lt[i*NT +: NT] = VEC[i][4:1];
            pulse(i);
            exp = '0;
            exp[i] = VEC[i][0];
            chk("R4 R8 table dout", dout, exp);
            chk("R5 table fb", fb, exp);
        end

        // R1 and R7: clear ignores polarity and clock
        step();
        byp = '0; ar = '1; pol = '1; lt = '1;
        step();
        chk("R1 clear with pol=1", fb, '0);
        pulse(3);
        chk("R1 clock ignored under clear", dout, '0);
        pol = '0;
        step();
        chk("R7 clear with pol=0", fb, '0);

        // R2 and R7: set ignores polarity
        ar = '0; ap = '1;
        step();
        chk("R2 set all cells", fb, '1);
        chk("R7 set with pol=0 and active sums", dout, '1);

        // R3: clear on the lower half wins over set
        ar = 10'b00000_11111;
        step();
        chk("R3 clear beats set", fb, 10'b11111_00000);

        ar = '0; ap = '0;
        step();
        chk("R3 release keeps state", fb, 10'b11111_00000);

        // R6: preload, polarity would give D=0 but is not applied
        pol = '1; lt = '0; pld = 10'b1010011100;
        step();
        ple = 1'b1;
        step();
        chk("R6 preload all cells", fb, 10'b1010011100);
        ple = 1'b0;
        step();
        chk("R6 preload value holds", fb, 10'b1010011100);

        // R6: clear on cell 2 blocks the preload there
        ar = 10'b0000000100;
        step();
        ple = 1'b1;
        step();
        chk("R6 clear over preload", fb, 10'b1010011000);
        ple = 1'b0;
        step();
        ar = '0;
        step();

        // R4 and R5: idle sum with pol=1 captures 0 into cell 4 only
        pulse(4);
        chk("R4 R5 capture on cell 4", fb, 10'b1010001000);

        // R9: sum change without a clock leaves the registered cell alone
        lt[4*NT] = 1'b1;
        step();
        step();
        chk("R9 hold between edges", dout, 10'b1010001000);
        pulse(4);
        chk("R4 active sum pol=1 captures 1", fb, 10'b1010011000);

        // R8: bypass follows sums with no clock
        byp[6] = 1'b1; pol[6] = 1'b1;
        lt[6*NT+2] = 1'b1;
        step();
        chk("R8 bypass dout", dout, 10'b1011011000);
        chk("R8 bypass feedback", fb, 10'b1011011000);
        byp[6] = 1'b0;
        step();
        chk("R9 back to flop", dout, 10'b1010011000);

        // R10: drive enable gating
        oet = '1; oep = 1'b0;
        step();
        chk("R10 shared enable low", den, '0);
        oep = 1'b1;
        step();
        chk("R10 both high", den, '1);
        oet = 10'h155;
        step();
        chk("R10 per-cell pattern", den, 10'h155);
        oep = 1'b0;
        step();
        chk("R10 pattern with shared low", den, '0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule